// File: doc/BRIEF.md
# Section Translation Cache with Entry Locking

This block translates 32-bit virtual addresses into physical addresses at a granularity of 1 MB sections. The address space splits into 4096 sections. A small fully associative cache of recent translations answers most requests combinationally, in the same cycle the request is presented. The low 20 address bits pass through unchanged. The upper 12 bits are replaced by the physical section number stored in the matching entry.

On a miss, the block reads one 32-bit descriptor from a table in memory. The descriptor address is formed from the table base and the 12-bit section index. A valid section descriptor is written into a cache entry, and the held request then completes as a hit on the following cycle. Fault descriptors, unsupported descriptor kinds and permission violations return an abort with a cause code instead of a translation.

A fill can mark its entry as locked. Locked entries survive both replacement and the invalidate-all command. When translation is disabled, the block returns the virtual address unchanged.

Top module: `sect_tlb`

## Requirements
- R1: After a synchronous reset, mem_req, resp_valid and fill_err are low, and no cache entry is valid, so the first translation of any section performs a table read.
- R2: With xlat_en low, a valid request is answered in the same cycle with resp_pa equal to req_va, resp_ap = 2'b11, no abort and no table read.
- R3: A request whose section matches a valid entry is answered in the same cycle without a table read. resp_pa is the entry's physical section number concatenated with req_va[19:0].
- R4: On a miss, exactly one table read is issued at address {ttb_base, req_va[31:20], 2'b00}. After a section descriptor is accepted, the held request is answered from the new entry on the next cycle.
- R5: Descriptor type is taken from bits 1:0. Types 00 and 11 abort with cause 1. Type 01, and type 10 with bit 18 set, abort with cause 2. Type 10 with bit 18 clear is a section whose physical section number is bits 31:20. Aborting descriptors are never cached. Cause 0 means no abort, and resp_abort is high exactly when the cause is non-zero.
- R6: A section's access field is descriptor bits 11:10. 00 denies every access. 01 allows privileged access only. 10 allows privileged access and user reads. 11 allows everything. A denied access aborts with cause 3, and the entry is still cached.
- R7: With no entries locked, fills pick victims in round-robin order, starting at entry 0 after reset.
- R8: A fill made with req_lock high marks its entry locked, and round-robin replacement skips that entry from then on.
- R9: A one-cycle inv_all pulse clears every unlocked entry at the next edge and leaves locked entries valid.
- R10: If every entry is locked when a section descriptor arrives, no fill happens. The request aborts with cause 4, and fill_err is high in the response cycle.
- R11: If a fill and inv_all fall on the same edge, the freshly filled entry stays valid and every other unlocked entry is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xlat_en | input | 1 | Translation enable; low gives identity mapping |
| ttb_base | input | 18 | Descriptor table base, address bits 31:14 |
| inv_all | input | 1 | Invalidate every unlocked entry |
| req_valid | input | 1 | Request present; held until resp_valid |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is unprivileged |
| req_lock | input | 1 | Lock the entry filled for this request |
| resp_valid | output | 1 | Response present this cycle |
| resp_pa | output | 32 | Physical address |
| resp_ap | output | 2 | Access field of the translation |
| resp_abort | output | 1 | Request aborted |
| resp_cause | output | 3 | Abort cause (0 none, 1 fault, 2 unsupported, 3 permission, 4 no victim) |
| fill_err | output | 1 | Fill refused because all entries are locked |
| mem_req | output | 1 | Descriptor read request, held until mem_ack |
| mem_addr | output | 32 | Descriptor address |
| mem_ack | input | 1 | Descriptor read done; mem_rdata valid |
| mem_rdata | input | 32 | Descriptor word |

## Verification
Filling an entry from a returned descriptor and the invalidate-all command can both land on the same clock edge. The bench provokes this by raising inv_all in exactly the cycle it acknowledges a descriptor read. It then judges the outcome at the ports. The section just filled must hit with no further table read. A section that was cached earlier and left unlocked must need a fresh walk. Locked sections are also checked after a standalone invalidate, to confirm they still hit.

// File: rtl/sect_tlb_pkg.sv
package sect_tlb_pkg;

  localparam logic [1:0] DT_FAULT = 2'b00;
  localparam logic [1:0] DT_TABLE = 2'b01;
  localparam logic [1:0] DT_SECT  = 2'b10;

  localparam int AP_LSB    = 10;
  localparam int SUPER_BIT = 18;

  typedef enum logic [2:0] {
    CAUSE_NONE  = 3'd0,
    CAUSE_FAULT = 3'd1,
    CAUSE_UNSUP = 3'd2,
    CAUSE_PERM  = 3'd3,
    CAUSE_NOWAY = 3'd4
  } cause_e;

  function automatic logic perm_ok(input logic [1:0] ap, input logic user, input logic write);
    case (ap)
      2'b00:   perm_ok = 1'b0;
      2'b01:   perm_ok = !user;
      2'b10:   perm_ok = !user || !write;
      default: perm_ok = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/sect_tlb_cam.sv
module sect_tlb_cam #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 12,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [TAG_W-1:0]   look_tag,
  output logic [ENTRIES-1:0] hit_vec,
  output logic               hit,
  output logic [TAG_W-1:0]   hit_ptag,
  output logic [1:0]         hit_ap,
  input  logic               fill_we,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [TAG_W-1:0]   fill_vtag,
  input  logic [TAG_W-1:0]   fill_ptag,
  input  logic [1:0]         fill_ap,
  input  logic               fill_lock,
  input  logic               inv_all,
  output logic [ENTRIES-1:0] ent_vld,
  output logic [ENTRIES-1:0] ent_lck
);

  logic [TAG_W-1:0] ptag_arr [ENTRIES];
  logic [1:0]       ap_arr   [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic             v_q, l_q;
    logic [TAG_W-1:0] vt_q, pt_q;
    logic [1:0]       ap_q;
    logic             sel;

    assign sel = fill_we && (fill_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        v_q  <= 1'b0;
        l_q  <= 1'b0;
        vt_q <= '0;
        pt_q <= '0;
        ap_q <= '0;
      end else if (sel) begin
        v_q  <= 1'b1;
        l_q  <= fill_lock;
        vt_q <= fill_vtag;
        pt_q <= fill_ptag;
        ap_q <= fill_ap;
      end else if (inv_all && !l_q) begin
        v_q  <= 1'b0;
      end
    end

    assign hit_vec[i]  = v_q && (vt_q == look_tag);
    assign ent_vld[i]  = v_q;
    assign ent_lck[i]  = l_q;
    assign ptag_arr[i] = pt_q;
    assign ap_arr[i]   = ap_q;
  end

  always_comb begin
    hit_ptag = '0;
    hit_ap   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      hit_ptag = hit_ptag | ({TAG_W{hit_vec[i]}} & ptag_arr[i]);
      hit_ap   = hit_ap   | ({2{hit_vec[i]}} & ap_arr[i]);
    end
  end

  assign hit = |hit_vec;

endmodule

// File: rtl/sect_tlb_victim.sv
module sect_tlb_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] locked,
  input  logic               advance,
  output logic [IDX_W-1:0]   victim,
  output logic               none_free
);

  localparam int unsigned N = ENTRIES;

  logic [IDX_W-1:0] ptr_q;

  function automatic logic [IDX_W-1:0] wrap_add(input logic [IDX_W-1:0] a, input int unsigned k);
    int unsigned s;
    s = k + {{(32-IDX_W){1'b0}}, a};
    if (s >= N) s = s - N;
    return s[IDX_W-1:0];
  endfunction

  always_comb begin
    logic found;
    logic [IDX_W-1:0] cand;
    found  = 1'b0;
    victim = ptr_q;
    for (int unsigned k = 0; k < N; k++) begin
      cand = wrap_add(ptr_q, k);
      if (!found && !locked[cand]) begin
        found  = 1'b1;
        victim = cand;
      end
    end
    none_free = !found;
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else if (advance) ptr_q <= wrap_add(victim, 1);
  end

endmodule

// File: rtl/sect_tlb_walker.sv
module sect_tlb_walker import sect_tlb_pkg::*; #(
  parameter int VA_W   = 32,
  parameter int SECT_W = 20,
  localparam int TAG_W = VA_W - SECT_W,
  localparam int TB_W  = VA_W - TAG_W - 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [TAG_W-1:0] start_tag,
  input  logic             start_lock,
  input  logic [TB_W-1:0]  ttb_base,
  input  logic             none_free,
  output logic             mem_req,
  output logic [VA_W-1:0]  mem_addr,
  input  logic             mem_ack,
  input  logic [VA_W-1:0]  mem_rdata,
  output logic             idle,
  output logic             fill_we,
  output logic [TAG_W-1:0] fill_vtag,
  output logic [TAG_W-1:0] fill_ptag,
  output logic [1:0]       fill_ap,
  output logic             fill_lock,
  output logic             resp,
  output cause_e           cause
);

  typedef enum logic [1:0] {W_IDLE, W_FETCH, W_RESP} wst_e;

  wst_e             st_q;
  logic [VA_W-1:0]  addr_q;
  logic [TAG_W-1:0] vtag_q;
  logic             lock_q;
  cause_e           cause_q;

  logic [1:0] typ;
  logic       is_sect;
  logic       rdata_unused;

  assign typ          = mem_rdata[1:0];
  assign is_sect      = (typ == DT_SECT) && !mem_rdata[SUPER_BIT];
  assign rdata_unused = ^{mem_rdata[SECT_W-1:SUPER_BIT+1], mem_rdata[SUPER_BIT-1:AP_LSB+2],
                          mem_rdata[AP_LSB-1:2]};

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= W_IDLE;
      addr_q  <= '0;
      vtag_q  <= '0;
      lock_q  <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      case (st_q)
        W_IDLE: if (start) begin
          st_q   <= W_FETCH;
          addr_q <= {ttb_base, start_tag, 2'b00};
          vtag_q <= start_tag;
          lock_q <= start_lock;
        end
        W_FETCH: if (mem_ack) begin
          if (is_sect && !none_free) begin
            st_q <= W_IDLE;
          end else begin
            st_q <= W_RESP;
            if (is_sect)                                 cause_q <= CAUSE_NOWAY;
            else if (typ == DT_TABLE || typ == DT_SECT) cause_q <= CAUSE_UNSUP;
            else                                         cause_q <= CAUSE_FAULT;
          end
        end
        W_RESP:  st_q <= W_IDLE;
        default: st_q <= W_IDLE;
      endcase
    end
  end

  assign mem_req   = (st_q == W_FETCH);
  assign mem_addr  = addr_q;
  assign idle      = (st_q == W_IDLE);
  assign fill_we   = mem_req && mem_ack && is_sect && !none_free;
  assign fill_vtag = vtag_q;
  assign fill_ptag = mem_rdata[VA_W-1:SECT_W];
  assign fill_ap   = mem_rdata[AP_LSB+1:AP_LSB];
  assign fill_lock = lock_q;
  assign resp      = (st_q == W_RESP);
  assign cause     = cause_q;

endmodule

// File: rtl/sect_tlb.sv
module sect_tlb import sect_tlb_pkg::*; #(
  parameter int VA_W    = 32,
  parameter int SECT_W  = 20,
  parameter int ENTRIES = 8,
  localparam int TAG_W  = VA_W - SECT_W,
  localparam int TB_W   = VA_W - TAG_W - 2,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            xlat_en,
  input  logic [TB_W-1:0] ttb_base,
  input  logic            inv_all,
  input  logic            req_valid,
  input  logic [VA_W-1:0] req_va,
  input  logic            req_write,
  input  logic            req_user,
  input  logic            req_lock,
  output logic            resp_valid,
  output logic [VA_W-1:0] resp_pa,
  output logic [1:0]      resp_ap,
  output logic            resp_abort,
  output logic [2:0]      resp_cause,
  output logic            fill_err,
  output logic            mem_req,
  output logic [VA_W-1:0] mem_addr,
  input  logic            mem_ack,
  input  logic [VA_W-1:0] mem_rdata
);

  logic [TAG_W-1:0]   req_tag;
  logic [ENTRIES-1:0] hit_vec, ent_vld, ent_lck;
  logic               hit;
  logic [TAG_W-1:0]   hit_ptag;
  logic [1:0]         hit_ap;
  logic               fill_we, fill_lock;
  logic [TAG_W-1:0]   fill_vtag, fill_ptag;
  logic [1:0]         fill_ap;
  logic [IDX_W-1:0]   victim;
  logic               none_free;
  logic               walk_idle, walk_resp, walk_start;
  cause_e             walk_cause;

  assign req_tag    = req_va[VA_W-1:SECT_W];
  assign walk_start = req_valid && xlat_en && !hit && walk_idle;

  sect_tlb_cam #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_cam (
    .clk(clk), .rst(rst), .look_tag(req_tag),
    .hit_vec(hit_vec), .hit(hit), .hit_ptag(hit_ptag), .hit_ap(hit_ap),
    .fill_we(fill_we), .fill_idx(victim), .fill_vtag(fill_vtag), .fill_ptag(fill_ptag),
    .fill_ap(fill_ap), .fill_lock(fill_lock), .inv_all(inv_all),
    .ent_vld(ent_vld), .ent_lck(ent_lck)
  );

  sect_tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst(rst), .locked(ent_vld & ent_lck), .advance(fill_we),
    .victim(victim), .none_free(none_free)
  );

  sect_tlb_walker #(.VA_W(VA_W), .SECT_W(SECT_W)) u_walker (
    .clk(clk), .rst(rst), .start(walk_start), .start_tag(req_tag), .start_lock(req_lock),
    .ttb_base(ttb_base), .none_free(none_free),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .idle(walk_idle), .fill_we(fill_we), .fill_vtag(fill_vtag), .fill_ptag(fill_ptag),
    .fill_ap(fill_ap), .fill_lock(fill_lock), .resp(walk_resp), .cause(walk_cause)
  );

  always_comb begin
    resp_valid = 1'b0;
    resp_pa    = '0;
    resp_ap    = '0;
    resp_abort = 1'b0;
    resp_cause = CAUSE_NONE;
    if (!xlat_en) begin
      resp_valid = req_valid;
      resp_pa    = req_va;
      resp_ap    = 2'b11;
    end else if (hit) begin
      resp_valid = req_valid;
      resp_ap    = hit_ap;
      if (perm_ok(hit_ap, req_user, req_write)) begin
        resp_pa = {hit_ptag, req_va[SECT_W-1:0]};
      end else begin
        resp_abort = 1'b1;
        resp_cause = CAUSE_PERM;
      end
    end else if (walk_resp) begin
      resp_valid = req_valid;
      resp_abort = 1'b1;
      resp_cause = walk_cause;
    end
  end

  assign fill_err = walk_resp && (walk_cause == CAUSE_NOWAY);

endmodule

// File: rtl/sect_tlb_chk.sv
module sect_tlb_chk #(
  parameter int VA_W    = 32,
  parameter int SECT_W  = 20,
  parameter int ENTRIES = 8,
  localparam int TAG_W  = VA_W - SECT_W,
  localparam int TB_W   = VA_W - TAG_W - 2
) (
  input logic               clk,
  input logic               rst,
  input logic               xlat_en,
  input logic [TB_W-1:0]    ttb_base,
  input logic               inv_all,
  input logic               req_valid,
  input logic [VA_W-1:0]    req_va,
  input logic               resp_valid,
  input logic [VA_W-1:0]    resp_pa,
  input logic               resp_abort,
  input logic [2:0]         resp_cause,
  input logic               fill_err,
  input logic               mem_req,
  input logic [VA_W-1:0]    mem_addr,
  input logic [ENTRIES-1:0] hit_vec,
  input logic [ENTRIES-1:0] ent_vld,
  input logic [ENTRIES-1:0] ent_lck
);

  AST_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !xlat_en) |-> (resp_valid && resp_pa == req_va && !resp_abort)); // R2

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec)); // R3

  AST_WALK_ADDR: assert property (@(posedge clk) disable iff (rst)
    (mem_req && req_valid) |-> (mem_addr[VA_W-1 -: TB_W] == ttb_base &&
      mem_addr[TAG_W+1:2] == req_va[VA_W-1:SECT_W] && mem_addr[1:0] == 2'b00)); // R4

  AST_CAUSE_MATCH: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> (resp_abort == (resp_cause != 3'd0))); // R5

  AST_LOCK_KEPT: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(ent_vld & ent_lck) & ~(ent_vld & ent_lck)) == '0)); // R8

  AST_INV_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(inv_all)) |-> ($countones(ent_vld & ~ent_lck) <= 1)); // R9

  AST_FILL_ERR: assert property (@(posedge clk) disable iff (rst)
    fill_err |-> (resp_abort && resp_cause == 3'd4)); // R10

endmodule

bind sect_tlb sect_tlb_chk #(.VA_W(VA_W), .SECT_W(SECT_W), .ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst(rst), .xlat_en(xlat_en), .ttb_base(ttb_base), .inv_all(inv_all),
  .req_valid(req_valid), .req_va(req_va), .resp_valid(resp_valid), .resp_pa(resp_pa),
  .resp_abort(resp_abort), .resp_cause(resp_cause), .fill_err(fill_err),
  .mem_req(mem_req), .mem_addr(mem_addr), .hit_vec(hit_vec), .ent_vld(ent_vld),
  .ent_lck(ent_lck)
);

// File: tb/sect_tlb_test.sv
module sect_tlb_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1, xlat_en = 1'b1, inv_all = 1'b0;
  logic [17:0] ttb_base = 18'h2A5C3;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0, req_lock = 1'b0;
  logic [31:0] req_va = '0;
  logic        resp_valid, resp_abort, fill_err, mem_req;
  logic [31:0] resp_pa, mem_addr;
  logic [1:0]  resp_ap;
  logic [2:0]  resp_cause;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [31:0] last_addr = '0;

  int n_chk = 0, n_bad = 0;

  sect_tlb uut (
    .clk(clk), .rst(rst), .xlat_en(xlat_en), .ttb_base(ttb_base), .inv_all(inv_all),
    .req_valid(req_valid), .req_va(req_va), .req_write(req_write), .req_user(req_user),
    .req_lock(req_lock), .resp_valid(resp_valid), .resp_pa(resp_pa), .resp_ap(resp_ap),
    .resp_abort(resp_abort), .resp_cause(resp_cause), .fill_err(fill_err),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // {va, write, user, abort, cause, walks}
  localparam int NV = 13;
  localparam logic [39:0] VEC [NV] = '{
    {32'h12345678, 1'b0, 1'b0, 1'b0, 3'd0, 2'd1},
    {32'h123ABCDE, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0},
    {32'h0F012345, 1'b0, 1'b0, 1'b1, 3'd1, 2'd1},
    {32'h0F100000, 1'b0, 1'b0, 1'b1, 3'd1, 2'd1},
    {32'h0F2ABCDE, 1'b0, 1'b0, 1'b1, 3'd2, 2'd1},
    {32'h0F311111, 1'b0, 1'b0, 1'b1, 3'd2, 2'd1},
    {32'h0A000010, 1'b0, 1'b0, 1'b1, 3'd3, 2'd1},
    {32'h0A100020, 1'b0, 1'b1, 1'b1, 3'd3, 2'd1},
    {32'h0A1FFFFF, 1'b1, 1'b0, 1'b0, 3'd0, 2'd0},
    {32'h0A200040, 1'b0, 1'b1, 1'b0, 3'd0, 2'd1},
    {32'h0A200044, 1'b1, 1'b1, 1'b1, 3'd3, 2'd0},
    {32'h12300000, 1'b1, 1'b1, 1'b0, 3'd0, 2'd0},
    {32'h0F0FFFFF, 1'b0, 1'b0, 1'b1, 3'd1, 2'd1}
  };
  string VTAG [NV] = '{"R4", "R3", "R5", "R5", "R5", "R5", "R6", "R6", "R6", "R6", "R6", "R3", "R5"};

  function automatic logic [11:0] base_of(input logic [11:0] idx);
    return idx ^ 12'h5A5;
  endfunction

  function automatic logic [1:0] ap_of(input logic [11:0] idx);
    case (idx)
      12'h0A0: return 2'b00;
      12'h0A1: return 2'b01;
      12'h0A2: return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

  function automatic logic [31:0] desc_of(input logic [11:0] idx);
    logic [31:0] d;
    d = '0;
    d[31:20] = base_of(idx);
    d[11:10] = ap_of(idx);
    d[1:0]   = 2'b10;
    case (idx)
      12'h0F0: d[1:0] = 2'b00;
      12'h0F1: d[1:0] = 2'b11;
      12'h0F2: d[1:0] = 2'b01;
      12'h0F3: d[18]  = 1'b1;
      default: ;
    endcase
    return d;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; req_valid = 1'b0; inv_all = 1'b0; mem_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic xlate(input logic [31:0] va, input bit wr, input bit usr, input bit lk,
                       input bit inv_ack, output bit got, output logic [31:0] pa,
                       output logic [1:0] ap, output bit ab, output logic [2:0] cs,
                       output int walks, output bit ferr);
    got = 0; pa = '0; ap = '0; ab = 0; cs = '0; walks = 0; ferr = 0;
    req_va = va; req_write = wr; req_user = usr; req_lock = lk; req_valid = 1'b1;
    for (int t = 0; t < 40; t++) begin
      #1;
      if (fill_err) ferr = 1;
      if (resp_valid) begin
        got = 1; pa = resp_pa; ap = resp_ap; ab = resp_abort; cs = resp_cause;
        break;
      end
      if (mem_req) begin
        mem_ack = 1'b1;
        mem_rdata = desc_of(mem_addr[13:2]);
        last_addr = mem_addr;
        inv_all = inv_ack;
        walks++;
      end
      @(negedge clk);
      mem_ack = 1'b0;
      inv_all = 1'b0;
    end
    req_valid = 1'b0;
    req_lock = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_ok(input logic [31:0] va, input bit lk, input int exp_walks,
                           input bit inv_ack, input string tag);
    bit got, ab, ferr;
    logic [31:0] pa;
    logic [1:0] ap;
    logic [2:0] cs;
    int walks;
    xlate(va, 1'b0, 1'b0, lk, inv_ack, got, pa, ap, ab, cs, walks, ferr);
    chk(got && !ab, tag, {got, ab}, 2'b10);
    chk(walks == exp_walks, tag, walks, exp_walks);
    chk(pa == {base_of(va[31:20]), va[19:0]}, tag, pa, {base_of(va[31:20]), va[19:0]});
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit got, ab, ferr;
    logic [31:0] pa;
    logic [1:0] ap;
    logic [2:0] cs;
    int walks;

    do_reset();
    #1;
    // R1: quiet outputs after reset
    chk(!resp_valid && !mem_req && !fill_err, "R1", {resp_valid, mem_req, fill_err}, 0);
    @(negedge clk);

    // table-driven walk through decode and permission cases
    for (int i = 0; i < NV; i++) begin
      logic [31:0] va;
      logic [2:0]  ecs;
      va  = VEC[i][39:8];
      ecs = VEC[i][4:2];
      xlate(va, VEC[i][7], VEC[i][6], 1'b0, 1'b0, got, pa, ap, ab, cs, walks, ferr);
      chk(got, VTAG[i], got, 1);
      chk(ab == VEC[i][5], VTAG[i], ab, VEC[i][5]);
      chk(cs == ecs, VTAG[i], cs, ecs);
      chk(walks == int'(VEC[i][1:0]), VTAG[i], walks, VEC[i][1:0]);
      if (!VEC[i][5]) begin
        chk(pa == {base_of(va[31:20]), va[19:0]}, VTAG[i], pa, {base_of(va[31:20]), va[19:0]});
        chk(ap == ap_of(va[31:20]), VTAG[i], ap, ap_of(va[31:20]));
      end
      if (i == 0) chk(last_addr == {18'h2A5C3, 12'h123, 2'b00}, "R4", last_addr, {18'h2A5C3, 12'h123, 2'b00});
    end

    // R2: identity mapping when disabled
    xlat_en = 1'b0;
    xlate(32'hDEADBEEF, 1'b1, 1'b1, 1'b0, 1'b0, got, pa, ap, ab, cs, walks, ferr);
    chk(got && !ab && pa == 32'hDEADBEEF, "R2", pa, 32'hDEADBEEF);
    chk(ap == 2'b11 && walks == 0, "R2", {ap, 8'(walks)}, {2'b11, 8'd0});
    xlat_en = 1'b1;

    // R1: reset forgets earlier entries
    do_reset();
    expect_ok(32'h12345678, 1'b0, 1, 1'b0, "R1");

    // R7: round-robin replacement
    do_reset();
    for (int k = 0; k < 9; k++) expect_ok({12'h200 + 12'(k), 20'h00100}, 1'b0, 1, 1'b0, "R7");
    expect_ok(32'h20200000, 1'b0, 0, 1'b0, "R7");
    expect_ok(32'h20000000, 1'b0, 1, 1'b0, "R7");

    // R8: locked entry survives replacement pressure
    do_reset();
    expect_ok(32'h30000abc, 1'b1, 1, 1'b0, "R8");
    for (int k = 0; k < 8; k++) expect_ok({12'h200 + 12'(k), 20'h00004}, 1'b0, 1, 1'b0, "R8");
    expect_ok(32'h30012345, 1'b0, 0, 1'b0, "R8");

    // R9: invalidate-all keeps locked, drops unlocked
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
    @(negedge clk);
    expect_ok(32'h30000000, 1'b0, 0, 1'b0, "R9");
    expect_ok(32'h20300000, 1'b0, 1, 1'b0, "R9");

    // R10: every entry locked
    do_reset();
    for (int k = 0; k < 8; k++) expect_ok({12'h400 + 12'(k), 20'h0}, 1'b1, 1, 1'b0, "R10");
    xlate(32'h40800000, 1'b0, 1'b0, 1'b0, 1'b0, got, pa, ap, ab, cs, walks, ferr);
    chk(got && ab && cs == 3'd4, "R10", {ab, cs}, {1'b1, 3'd4});
    chk(ferr && walks == 1, "R10", {ferr, 8'(walks)}, {1'b1, 8'd1});
    expect_ok(32'h40400000, 1'b0, 0, 1'b0, "R10");

    // R11: fill and invalidate on the same edge
    do_reset();
    expect_ok(32'h50000000, 1'b0, 1, 1'b0, "R11");
    expect_ok(32'h50100000, 1'b0, 1, 1'b1, "R11");
    expect_ok(32'h50100000, 1'b0, 0, 1'b0, "R11");
    expect_ok(32'h50000000, 1'b0, 1, 1'b0, "R11");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule